// File: doc/BRIEF.md
# Serial Flash Command Engine

This block is a register-driven SPI master for a serial flash device. Software writes a command and its payload into a shared 64-byte buffer. It programs the length of the shift as a bit count and chooses whether chip select stays low after the command. It then sets a start bit. The engine clocks the buffer out on MOSI, most significant bit first within each byte. When input capture is enabled, it writes each MISO bit back over the bit that was just sent, so after the command the buffer holds the flash's reply.

The engine runs in SPI mode 0 with one chip select and byte-oriented data. A register bit enables the bus-mapped flash window and is passed out on a pin. While that window is enabled, user commands are refused. A write-only reset bit aborts any command in flight. A sticky completion flag tells polling software that the shift has finished.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, chip select is high (inactive), SCLK is low, the command register (0x00) reads 0, the control register (0x08) reads 0x0002_0000 (window enable on bit 17), the clock register (0x18) reads 1 and the slave register (0x30) reads 0.
- R2: Writing 1 to bit 18 of 0x00 while idle starts a command. Bit 18 of 0x00 reads 1 for as long as the command runs and reads 0 once it finishes.
- R3: A command shifts (user1[25:17] at 0x20) + 1 bits. Bit n of the stream is bit 7−(n mod 8) of buffer byte n/8. Buffer word k is at 0x40 + 4·k, and byte 4k sits in bits 7:0 of that word.
- R4: SPI mode 0 is used. SCLK idles low. MOSI changes only while SCLK is low. Each SCLK half period lasts (clock[5:0] at 0x18) + 1 clock cycles.
- R5: With bit 0 of the user register (0x1C) set, MISO is sampled on each rising SCLK edge and overwrites the buffer bit just sent. With bit 0 clear, the buffer is left unchanged.
- R6: With bit 27 of 0x1C clear, MOSI is held at 0 for the whole command. With it set, MOSI carries the buffer.
- R7: Bit 4 of 0x30 becomes 1 when a command completes. Writing 0x30 with bit 4 = 0 clears it. Writing bit 4 = 1 never sets it.
- R8: Chip select is low throughout a command. At the end it returns high if bit 30 of user4 (0x2C) is 0, and stays low if that bit is 1.
- R9: A start request is ignored while bit 17 of 0x08 (window enable) is 1 or bit 30 of 0x30 (operating mode, 1 = non-master) is 1.
- R10: Bus writes to the buffer are ignored while a command runs.
- R11: Writing 1 to bit 31 of 0x30 aborts any command. It returns chip select high and SCLK low, clears the completion flag, and the bit reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_we | input | 1 | Write (1) or read (0) |
| bus_addr | input | 7 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| map_en | output | 1 | Bus-mapped flash window enable |
| spi_sclk | output | 1 | Serial clock |
| spi_csn | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The embedded assertions check the following on every cycle:
- chip select is low whenever a command is busy;
- SCLK is low whenever the engine is idle;
- MOSI does not move while SCLK is high;
- the half-period tick never fires on two cycles in a row when the divider is above zero;
- the buffer stays frozen during a command except where a capture writes it;
- a refused start leaves the engine idle;
- every normal finish raises the completion flag.

Some behaviour only the bench scenarios can show:
- the MSB-first byte order on the wire and the buffer left after capture;
- the measured half-period length;
- the held chip select carried across two commands;
- the abort midway through a command.

// File: rtl/fce_pkg.sv
`timescale 1ns/1ps
package fce_pkg;
   // register offsets (byte addresses on the 7-bit bus)
   localparam logic [6:0] OFS_CMD  = 7'h00;
   localparam logic [6:0] OFS_CTRL = 7'h08;
   localparam logic [6:0] OFS_CLK  = 7'h18;
   localparam logic [6:0] OFS_USER = 7'h1C;
   localparam logic [6:0] OFS_LEN  = 7'h20;
   localparam logic [6:0] OFS_CSH  = 7'h2C;
   localparam logic [6:0] OFS_SLV  = 7'h30;

   // bit positions
   localparam int BIT_START  = 18;
   localparam int BIT_MAPEN  = 17;
   localparam int BIT_CAPEN  = 0;
   localparam int BIT_COMPAT = 2;
   localparam int BIT_DOUT   = 27;
   localparam int LEN_LSB    = 17;
   localparam int BIT_CSHOLD = 30;
   localparam int BIT_DONE   = 4;
   localparam int BIT_MODE   = 30;
   localparam int BIT_SRST   = 31;

   typedef struct packed {
      logic cap_en;
      logic dout_en;
      logic cs_hold;
   } fce_cfg_t;
endpackage

// File: rtl/fce_regs.sv
`timescale 1ns/1ps
module fce_regs
   import fce_pkg::*;
#(
   parameter int DIV_W = 6,
   parameter int LEN_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             we,
   input  logic [6:0]       addr,
   input  logic [31:0]      wdata,
   input  logic             busy,
   input  logic             xfer_done,
   output logic             start_req,
   output logic             srst,
   output logic             map_en,
   output logic [DIV_W-1:0] half_div,
   output logic [LEN_W-1:0] nbits_m1,
   output fce_cfg_t         cfg,
   output logic             done_flag,
   output logic [31:0]      rdata
);
   initial begin
      assert (DIV_W >= 1 && DIV_W <= 16) else $error("DIV_W out of range");
      assert (LEN_LSB + LEN_W <= 32) else $error("LEN_W too wide for length field");
   end

   logic             wr;
   logic             map_q, cap_q, compat_q, dout_q, hold_q, done_q, mode_q;
   logic [DIV_W-1:0] div_q;
   logic [LEN_W-1:0] len_q;

   assign wr = sel & we;

   assign start_req = wr && (addr == OFS_CMD) && wdata[BIT_START] && !busy
                      && !map_q && !mode_q;
   assign srst      = wr && (addr == OFS_SLV) && wdata[BIT_SRST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_q    <= 1'b1;
         div_q    <= DIV_W'(1);
         cap_q    <= 1'b0;
         compat_q <= 1'b0;
         dout_q   <= 1'b0;
         len_q    <= '0;
         hold_q   <= 1'b0;
         mode_q   <= 1'b0;
      end else if (wr) begin
         case (addr)
            OFS_CTRL: map_q <= wdata[BIT_MAPEN];
            OFS_CLK:  div_q <= wdata[DIV_W-1:0];
            OFS_USER: begin
               cap_q    <= wdata[BIT_CAPEN];
               compat_q <= wdata[BIT_COMPAT];
               dout_q   <= wdata[BIT_DOUT];
            end
            OFS_LEN:  len_q  <= wdata[LEN_LSB +: LEN_W];
            OFS_CSH:  hold_q <= wdata[BIT_CSHOLD];
            OFS_SLV:  mode_q <= wdata[BIT_MODE];
            default: ;
         endcase
      end
   end

   // sticky completion flag: reset abort > hardware set > software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         done_q <= 1'b0;
      else if (srst)
         done_q <= 1'b0;
      else if (xfer_done)
         done_q <= 1'b1;
      else if (wr && (addr == OFS_SLV) && !wdata[BIT_DONE])
         done_q <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         OFS_CMD:  rdata[BIT_START] = busy;
         OFS_CTRL: rdata[BIT_MAPEN] = map_q;
         OFS_CLK:  rdata[DIV_W-1:0] = div_q;
         OFS_USER: begin
            rdata[BIT_CAPEN]  = cap_q;
            rdata[BIT_COMPAT] = compat_q;
            rdata[BIT_DOUT]   = dout_q;
         end
         OFS_LEN:  rdata[LEN_LSB +: LEN_W] = len_q;
         OFS_CSH:  rdata[BIT_CSHOLD] = hold_q;
         OFS_SLV:  begin
            rdata[BIT_DONE] = done_q;
            rdata[BIT_MODE] = mode_q;
         end
         default: ;
      endcase
   end

   assign map_en    = map_q;
   assign half_div  = div_q;
   assign nbits_m1  = len_q;
   assign cfg       = '{cap_en: cap_q, dout_en: dout_q, cs_hold: hold_q};
   assign done_flag = done_q;

   AST_SRST_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> !done_q); // R11
endmodule

// File: rtl/fce_clkgen.sv
`timescale 1ns/1ps
module fce_clkgen #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || cnt_q == half_div)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign tick = run && (cnt_q == half_div);

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && half_div != '0 && $stable(half_div)) |=> !tick); // R4
endmodule

// File: rtl/fce_buffer.sv
`timescale 1ns/1ps
module fce_buffer #(
   parameter int BUF_BYTES = 64,
   parameter int LEN_W     = 9,
   localparam int WORDS    = BUF_BYTES / 4,
   localparam int WIDX     = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   input  logic             wr_en,
   input  logic [WIDX-1:0]  wr_word,
   input  logic [31:0]      wr_data,
   input  logic [WIDX-1:0]  rd_word,
   output logic [31:0]      rd_data,
   input  logic             cap_we,
   input  logic [LEN_W-1:0] cap_idx,
   input  logic             cap_bit,
   input  logic [LEN_W-1:0] tx_idx,
   output logic             tx_bit
);
   initial begin
      assert (BUF_BYTES % 4 == 0 && WORDS >= 2) else $error("BUF_BYTES must be a multiple of 4, at least 8");
      assert ((1 << LEN_W) == BUF_BYTES * 8) else $error("LEN_W must address every buffer bit");
   end

   // stream bit n -> storage bit: byte n/8, bit 7-(n%8)
   function automatic logic [LEN_W-1:0] flat_pos(input logic [LEN_W-1:0] n);
      return {n[LEN_W-1:3], ~n[2:0]};
   endfunction

   logic [BUF_BYTES*8-1:0] store_q;
   logic [LEN_W-1:0]       cap_pos;
   logic [31:0]            word_view [WORDS];

   assign cap_pos = flat_pos(cap_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_q <= '0;
      end else begin
         if (wr_en && !busy)
            store_q[32*int'(wr_word) +: 32] <= wr_data;
         if (cap_we)
            store_q[cap_pos] <= cap_bit;
      end
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_view
      assign word_view[w] = store_q[32*w +: 32];
   end

   assign rd_data = word_view[rd_word];
   assign tx_bit  = store_q[flat_pos(tx_idx)];

   AST_BUF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cap_we) |=> $stable(store_q)); // R10
endmodule

// File: rtl/fce_shifter.sv
`timescale 1ns/1ps
module fce_shifter
   import fce_pkg::*;
#(
   parameter int LEN_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic             srst,
   input  logic             tick,
   input  fce_cfg_t         cfg,
   input  logic [LEN_W-1:0] nbits_m1,
   input  logic             tx_bit,
   input  logic             miso,
   output logic [LEN_W-1:0] tx_idx,
   output logic             cap_we,
   output logic [LEN_W-1:0] cap_idx,
   output logic             cap_bit,
   output logic             busy,
   output logic             xfer_done,
   output logic             sclk,
   output logic             csn,
   output logic             mosi
);
   logic             busy_q, sclk_q, csn_q, mosi_q, cap_lat, dout_lat;
   logic [LEN_W-1:0] idx_q, last_q;
   logic             last_bit;

   assign last_bit = (idx_q == last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         sclk_q   <= 1'b0;
         csn_q    <= 1'b1;
         mosi_q   <= 1'b0;
         idx_q    <= '0;
         last_q   <= '0;
         cap_lat  <= 1'b0;
         dout_lat <= 1'b0;
      end else if (srst) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
         csn_q  <= 1'b1;
         mosi_q <= 1'b0;
      end else if (!busy_q) begin
         if (start_req) begin
            busy_q   <= 1'b1;
            csn_q    <= 1'b0;
            sclk_q   <= 1'b0;
            idx_q    <= '0;
            last_q   <= nbits_m1;
            cap_lat  <= cfg.cap_en;
            dout_lat <= cfg.dout_en;
            mosi_q   <= cfg.dout_en & tx_bit;
         end
      end else if (tick) begin
         if (!sclk_q) begin
            sclk_q <= 1'b1;                 // rising edge: sample
         end else begin
            sclk_q <= 1'b0;                 // falling edge: advance
            if (last_bit) begin
               busy_q <= 1'b0;
               csn_q  <= !cfg.cs_hold;
            end else begin
               idx_q  <= idx_q + 1'b1;
               mosi_q <= dout_lat & tx_bit;
            end
         end
      end
   end

   assign tx_idx    = busy_q ? idx_q + 1'b1 : '0;
   assign cap_we    = busy_q && tick && !sclk_q && cap_lat && !srst;
   assign cap_idx   = idx_q;
   assign cap_bit   = miso;
   assign xfer_done = busy_q && tick && sclk_q && last_bit && !srst;

   assign busy = busy_q;
   assign sclk = sclk_q;
   assign csn  = csn_q;
   assign mosi = mosi_q;

   AST_CS_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !csn_q); // R8
   AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !sclk_q); // R4
   AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && sclk_q) |-> $stable(mosi_q)); // R4
   AST_MOSI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !dout_lat) |-> !mosi_q); // R6
endmodule

// File: rtl/flash_cmd_engine.sv
`timescale 1ns/1ps
module flash_cmd_engine
   import fce_pkg::*;
#(
   parameter int BUF_BYTES = 64,
   parameter int DIV_W     = 6,
   localparam int LEN_W    = $clog2(BUF_BYTES * 8),
   localparam int WIDX     = $clog2(BUF_BYTES / 4)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_we,
   input  logic [6:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        map_en,
   output logic        spi_sclk,
   output logic        spi_csn,
   output logic        spi_mosi,
   input  logic        spi_miso
);
   initial begin
      assert (BUF_BYTES <= 64) else $error("buffer window holds at most 64 bytes");
   end

   logic             buf_hit, start_req, srst, busy, xfer_done, tick, done_flag;
   logic             cap_we, cap_bit, tx_bit;
   logic [DIV_W-1:0] half_div;
   logic [LEN_W-1:0] nbits_m1, tx_idx, cap_idx;
   logic [31:0]      reg_rdata, buf_rdata;
   fce_cfg_t         cfg;

   assign buf_hit = bus_addr[6];

   fce_regs #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
      .wdata(bus_wdata), .busy(busy), .xfer_done(xfer_done),
      .start_req(start_req), .srst(srst), .map_en(map_en), .half_div(half_div),
      .nbits_m1(nbits_m1), .cfg(cfg), .done_flag(done_flag), .rdata(reg_rdata)
   );

   fce_clkgen #(.DIV_W(DIV_W)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .run(busy), .half_div(half_div), .tick(tick)
   );

   fce_buffer #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_buffer (
      .clk(clk), .rst_n(rst_n), .busy(busy),
      .wr_en(bus_sel && bus_we && buf_hit), .wr_word(bus_addr[2 +: WIDX]),
      .wr_data(bus_wdata), .rd_word(bus_addr[2 +: WIDX]), .rd_data(buf_rdata),
      .cap_we(cap_we), .cap_idx(cap_idx), .cap_bit(cap_bit),
      .tx_idx(tx_idx), .tx_bit(tx_bit)
   );

   fce_shifter #(.LEN_W(LEN_W)) u_shifter (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .srst(srst), .tick(tick),
      .cfg(cfg), .nbits_m1(nbits_m1), .tx_bit(tx_bit), .miso(spi_miso),
      .tx_idx(tx_idx), .cap_we(cap_we), .cap_idx(cap_idx), .cap_bit(cap_bit),
      .busy(busy), .xfer_done(xfer_done), .sclk(spi_sclk), .csn(spi_csn),
      .mosi(spi_mosi)
   );

   assign bus_rdata = buf_hit ? buf_rdata : reg_rdata;

   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !$past(srst)) |-> done_flag); // R7
   AST_NO_START_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (map_en && !busy && !srst) |=> !busy); // R9
endmodule

// File: tb/flash_cmd_engine_bench.sv
`timescale 1ns/1ps
module flash_cmd_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        map_en, spi_sclk, spi_csn, spi_mosi;
   logic        spi_miso;

   int checks = 0;
   int errors = 0;
   logic [7:0] tx_mem [64];
   logic [7:0] resp_mem [64];
   logic [7:0] exp_q [$];
   int   miso_idx = 0;
   int   mon_cnt = 0;
   logic [7:0] mon_byte = '0;

   always #2 clk = ~clk;   // 250 MHz

   flash_cmd_engine u_flash_cmd_engine (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .map_en(map_en), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   // flash model: reply stream, MSB first per byte
   always @* begin
      if (miso_idx < 512) spi_miso = resp_mem[miso_idx / 8][7 - (miso_idx % 8)];
      else                spi_miso = 1'b0;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: scoreboard of MOSI bytes, advances the flash reply
   always @(posedge spi_sclk) begin
      mon_byte = {mon_byte[6:0], spi_mosi};
      mon_cnt++;
      miso_idx++;
      if (mon_cnt == 8) begin
         mon_cnt = 0;
         if (exp_q.size() == 0) check("R3 unexpected MOSI byte", {24'h0, mon_byte}, 32'hFFFF_FFFF);
         else check("R3/R6 MOSI byte", {24'h0, mon_byte}, {24'h0, exp_q.pop_front()});
      end
   end
   always @(posedge spi_csn) mon_cnt = 0;

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   function automatic logic [31:0] pack(input int k, input logic src);
      logic [31:0] v;
      for (int b = 0; b < 4; b++) v[8*b +: 8] = src ? resp_mem[4*k+b] : tx_mem[4*k+b];
      return v;
   endfunction

   task automatic load_buf(input int nbytes);
      for (int k = 0; k < nbytes / 4; k++) wr(7'h40 + 7'(4*k), pack(k, 1'b0));
   endtask

   // driver: pushes expected MOSI bytes, programs and starts a command
   task automatic launch(input int nbytes, input logic dout, input logic cap, input logic hold);
      for (int k = 0; k < nbytes; k++) exp_q.push_back(dout ? tx_mem[k] : 8'h00);
      wr(7'h1C, (32'(dout) << 27) | 32'(cap));
      wr(7'h20, 32'(nbytes * 8 - 1) << 17);
      wr(7'h2C, 32'(hold) << 30);
      wr(7'h30, 32'h0);
      miso_idx = 0;
      wr(7'h00, 32'h0004_0000);
   endtask

   task automatic wait_done(input string req);
      logic [31:0] v;
      int n = 0;
      v = '0;
      while (!v[4] && n < 20000) begin rd(7'h30, v); n++; end
      check(req, {31'h0, v[4]}, 32'h1);
   endtask

   task automatic report;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #800000;
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      report();
      $finish;
   end

   initial begin
      logic [31:0] v;
      realtime t0, t1;
      for (int k = 0; k < 64; k++) begin
         tx_mem[k]   = 8'(k * 53 + 165);
         resp_mem[k] = 8'(k * 37 + 11);
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 csn", {31'h0, spi_csn}, 32'h1);
      check("R1 sclk", {31'h0, spi_sclk}, 32'h0);
      rd(7'h00, v); check("R1 cmd", v, 32'h0);
      rd(7'h08, v); check("R1 ctrl", v, 32'h0002_0000);
      rd(7'h18, v); check("R1 clock", v, 32'h1);
      rd(7'h30, v); check("R1 slave", v, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      wr(7'h08, 32'h0);

      // R2/R3/R5: 8-byte exchange with capture
      load_buf(8);
      launch(8, 1'b1, 1'b1, 1'b0);
      rd(7'h00, v); check("R2 busy while running", v, 32'h0004_0000);
      wait_done("R7 done after exchange");
      rd(7'h00, v); check("R2 start bit clears", v, 32'h0);
      check("R8 csn released", {31'h0, spi_csn}, 32'h1);
      for (int k = 0; k < 2; k++) begin
         rd(7'h40 + 7'(4*k), v); check("R5 captured reply", v, pack(k, 1'b1));
      end

      // R4/R5: slower clock, no capture
      wr(7'h18, 32'd3);
      load_buf(4);
      launch(2, 1'b1, 1'b0, 1'b0);
      @(posedge spi_sclk); t0 = $realtime;
      @(negedge spi_sclk); t1 = $realtime;
      check("R4 half period cycles", 32'(int'((t1 - t0) / 4.0)), 32'd4);
      wait_done("R7 done slow");
      rd(7'h40, v); check("R5 buffer kept without capture", v, pack(0, 1'b0));
      wr(7'h18, 32'd1);

      // R6: data-out phase disabled
      launch(1, 1'b0, 1'b0, 1'b0);
      wait_done("R6 done");

      // R8: chip select held, then released
      launch(1, 1'b1, 1'b0, 1'b1);
      wait_done("R8 done held");
      repeat (4) @(negedge clk);
      check("R8 csn held low", {31'h0, spi_csn}, 32'h0);
      launch(1, 1'b1, 1'b0, 1'b0);
      wait_done("R8 done release");
      check("R8 csn high after release", {31'h0, spi_csn}, 32'h1);

      // R7: writing 1 to done never sets it
      wr(7'h30, 32'h0); rd(7'h30, v); check("R7 cleared", v, 32'h0);
      wr(7'h30, 32'h10); rd(7'h30, v); check("R7 write one ignored", v, 32'h0);

      // R9: start refused with window enabled or non-master mode
      wr(7'h08, 32'h0002_0000);
      wr(7'h00, 32'h0004_0000);
      rd(7'h00, v); check("R9 refused window", v, 32'h0);
      check("R9 csn idle window", {31'h0, spi_csn}, 32'h1);
      wr(7'h08, 32'h0);
      wr(7'h30, 32'h4000_0000);
      wr(7'h00, 32'h0004_0000);
      repeat (20) @(negedge clk);
      rd(7'h30, v); check("R9 refused mode", v, 32'h4000_0000);
      wr(7'h30, 32'h0);

      // R10: buffer write during command ignored
      load_buf(8);
      launch(8, 1'b1, 1'b0, 1'b0);
      wr(7'h40, 32'hDEAD_BEEF);
      wait_done("R10 done");
      rd(7'h40, v); check("R10 write ignored", v, pack(0, 1'b0));

      // R11: soft reset aborts
      wr(7'h20, 32'(63) << 17);
      wr(7'h30, 32'h0);
      wr(7'h00, 32'h0004_0000);
      repeat (12) @(negedge clk);
      wr(7'h30, 32'h8000_0000);
      check("R11 csn released", {31'h0, spi_csn}, 32'h1);
      check("R11 sclk low", {31'h0, spi_sclk}, 32'h0);
      rd(7'h00, v); check("R11 idle", v, 32'h0);
      rd(7'h30, v); check("R11 slave reads zero", v, 32'h0);

      repeat (10) @(negedge clk);
      check("R3 scoreboard drained", 32'(exp_q.size()), 32'h0);
      report();
      $finish;
   end
endmodule